// File: doc/BRIEF.md
# Address-First Serial Register Bus Master

This block runs register transactions on a four-wire serial bus. The wires are a serial clock, a command line driven by the master, a reply line driven by the slave, and one active-low select per slave. Every transaction opens with one register address. Three things can follow the address: nothing, a payload written to the slave, or a payload read back from it. The payload is one byte or two bytes. An address-only transaction sends a bare command, for example the general reset value 0x01.

A host starts a transaction with a one-cycle request that carries the slave index, the address, the transfer kind, the width and the write data. While the transaction runs, `busy` is high. When it ends, a one-cycle `done` pulse is raised and the read data is presented with it. The host sets the serial rate through a divider register. The divider value is taken at the start of each transaction. Each slave's active-low interrupt line is synchronised and reported to the host as an active-high pending flag.

Top module: `sreg_bus_master`

## Requirements
- R1: The first 8 serial bits of every transaction carry the register address, most significant bit first, on `cmd_out`.
- R2: A write (`req_kind`=1) follows the address with 8 bits from `req_wdata[7:0]`, or with 16 bits from `req_wdata[15:0]` when `req_wide`=1. Each payload is sent most significant bit first, so the high byte goes first.
- R3: A read (`req_kind`=2) samples 8 or 16 payload bits from `reply_in`, MSB first, while `cmd_out` stays 0. `rd_data` returns the 16 bits, or the 8 bits zero-extended. It returns 0 after a write or an address-only transaction.
- R4: An address-only transaction (`req_kind`=0, and also the unused code 3) sends exactly 8 clocks, and `req_wide` has no effect on it.
- R5: Only the select `cs_n[req_dev]` goes low during a transaction. At most one select is ever low, and all selects are high when idle.
- R6: `sclk` is high whenever no select is low. `cmd_out` changes only on a falling edge of `sclk` or while no select is low, and is therefore stable at every rising edge.
- R7: Each half period of `sclk` lasts D+1 system clocks, where D is the divider value taken at the start. The select falls D+1 clocks before the first falling edge and rises D+1 clocks after the last rising edge.
- R8: A start request is ignored while `busy` is high. It does not change the current transfer and causes no further select activity or `done` pulse.
- R9: `done` is a single-cycle pulse in the cycle in which `busy` falls and the select rises.
- R10: The divider register resets to `DIV_RESET` and is written by `cfg_we`. A write made during a transaction does not change that transaction's timing.
- R11: `irq_pend[i]` equals the inverse of `irq_n[i]` two system clocks after that input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the divider register |
| cfg_div | input | DIV_W | New divider value |
| req_start | input | 1 | One-cycle transaction request |
| req_dev | input | SEL_W | Index of the slave to select |
| req_kind | input | 2 | 0 address only, 1 write, 2 read, 3 treated as 0 |
| req_wide | input | 1 | 1 for a 16-bit payload, 0 for an 8-bit payload |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 2*BYTE_W | Write payload |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | End-of-transaction pulse |
| rd_data | output | 2*BYTE_W | Read payload |
| irq_pend | output | NUM_SLAVES | Synchronised interrupt pending flags |
| sclk | output | 1 | Serial clock, idles high |
| cmd_out | output | 1 | Command data to the slaves |
| reply_in | input | 1 | Reply data from the selected slave |
| cs_n | output | NUM_SLAVES | Active-low slave selects |
| irq_n | input | NUM_SLAVES | Active-low interrupt requests |

## Verification
The bench builds the block with 8-bit bytes, two slaves and a 4-bit divider that resets to 2. Because the divider is so small, it can sweep divider values 0 to 3 across both slaves, all three transfer kinds and both widths. Each transaction takes at most a few hundred cycles. Expected command bits, read data and edge timings are computed from the divider arithmetic. The small configuration also lets the bench place a second start request and a divider write in the middle of a live transfer.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;
   typedef enum logic [1:0] {
      XK_ADDR  = 2'd0,
      XK_WRITE = 2'd1,
      XK_READ  = 2'd2,
      XK_RSVD  = 2'd3
   } xfer_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_LOW   = 2'd2,
      PH_HIGH  = 2'd3
   } phase_e;
endpackage

// File: rtl/sreg_half_timer.sv
`timescale 1ns/1ps
module sreg_half_timer #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] div_in,
   input  logic             run,
   output logic             tick
);
   logic [DIV_W-1:0] div_lat;
   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div_lat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_lat <= '0;
         cnt     <= '0;
      end else if (load) begin
         div_lat <= div_in;
         cnt     <= '0;
      end else if (run) begin
         cnt <= tick ? '0 : cnt + 1'b1;
      end
   end

   // R10
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load) |=> $stable(div_lat));
endmodule

// File: rtl/sreg_shifter.sv
`timescale 1ns/1ps
module sreg_shifter #(
   parameter int FRAME_W = 24,
   parameter int RX_W    = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic               adv,
   input  logic               smp,
   input  logic               din,
   output logic               dout,
   output logic [RX_W-1:0]    rx
);
   logic [FRAME_W-1:0] tx;

   assign dout = tx[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx <= '0;
         rx <= '0;
      end else if (load) begin
         tx <= frame;
         rx <= '0;
      end else begin
         if (adv) tx <= {tx[FRAME_W-2:0], 1'b0};
         if (smp) rx <= {rx[RX_W-2:0], din};
      end
   end
endmodule

// File: rtl/sreg_irq_sync.sv
`timescale 1ns/1ps
module sreg_irq_sync #(
   parameter int NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] irq_n,
   output logic [NUM-1:0] pend
);
   for (genvar i = 0; i < NUM; i++) begin : g_ch
      logic s1, s2;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
         end else begin
            s1 <= irq_n[i];
            s2 <= s1;
         end
      end
      assign pend[i] = ~s2;
   end
endmodule

// File: rtl/sreg_bus_master.sv
`timescale 1ns/1ps
module sreg_bus_master #(
   parameter int ADDR_W     = 8,
   parameter int BYTE_W     = 8,
   parameter int NUM_SLAVES = 2,
   parameter int DIV_W      = 4,
   parameter int DIV_RESET  = 2,
   localparam int DATA_W    = 2 * BYTE_W,
   localparam int SEL_W     = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [DIV_W-1:0]      cfg_div,
   input  logic                  req_start,
   input  logic [SEL_W-1:0]      req_dev,
   input  logic [1:0]            req_kind,
   input  logic                  req_wide,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  busy,
   output logic                  done,
   output logic [DATA_W-1:0]     rd_data,
   output logic [NUM_SLAVES-1:0] irq_pend,
   output logic                  sclk,
   output logic                  cmd_out,
   input  logic                  reply_in,
   output logic [NUM_SLAVES-1:0] cs_n,
   input  logic [NUM_SLAVES-1:0] irq_n
);
   import sreg_pkg::*;

   localparam int FRAME_W = ADDR_W + DATA_W;
   localparam int BIT_W   = $clog2(FRAME_W + 1);

   if (ADDR_W < 1 || BYTE_W < 1) begin : g_bad_width
      $error("ADDR_W and BYTE_W must be positive");
   end
   if (NUM_SLAVES < 1) begin : g_bad_slaves
      $error("NUM_SLAVES must be at least 1");
   end
   if (DIV_RESET >= (1 << DIV_W)) begin : g_bad_div
      $error("DIV_RESET does not fit in DIV_W bits");
   end

   phase_e                ph;
   logic [DIV_W-1:0]      div_q;
   logic [BIT_W-1:0]      bit_q, last_q;
   logic                  rd_q;
   logic                  sclk_q;
   logic                  done_q;
   logic [DATA_W-1:0]     rdat_q;
   logic [NUM_SLAVES-1:0] cs_q;
   logic                  tick, accept, is_last;
   logic                  tx_bit;
   logic [DATA_W-1:0]     rx;
   logic [FRAME_W-1:0]    frame;
   logic [BIT_W-1:0]      nbits;
   xfer_kind_e            kind;

   assign kind    = xfer_kind_e'(req_kind);
   assign accept  = req_start && (ph == PH_IDLE);
   assign is_last = (bit_q == last_q);

   always_comb begin
      frame = '0;
      nbits = BIT_W'(ADDR_W);
      frame[FRAME_W-1 -: ADDR_W] = req_addr;
      if (kind == XK_WRITE || kind == XK_READ) begin
         nbits = req_wide ? BIT_W'(FRAME_W) : BIT_W'(ADDR_W + BYTE_W);
      end
      if (kind == XK_WRITE) begin
         if (req_wide) frame[DATA_W-1:0] = req_wdata;
         else          frame[DATA_W-1 -: BYTE_W] = req_wdata[BYTE_W-1:0];
      end
   end

   // divider register, taken into the timer only when a transfer starts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= DIV_W'(DIV_RESET);
      else if (cfg_we) div_q <= cfg_div;
   end

   sreg_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(accept), .div_in(div_q),
      .run(ph != PH_IDLE), .tick(tick)
   );

   sreg_shifter #(.FRAME_W(FRAME_W), .RX_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(accept), .frame(frame),
      .adv(ph == PH_HIGH && tick && !is_last),
      .smp(ph == PH_LOW && tick && rd_q && (bit_q >= BIT_W'(ADDR_W))),
      .din(reply_in), .dout(tx_bit), .rx(rx)
   );

   sreg_irq_sync #(.NUM(NUM_SLAVES)) u_irq (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .pend(irq_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         bit_q  <= '0;
         last_q <= '0;
         rd_q   <= 1'b0;
         sclk_q <= 1'b1;
         done_q <= 1'b0;
         rdat_q <= '0;
         cs_q   <= '1;
      end else begin
         done_q <= 1'b0;
         case (ph)
            PH_IDLE: if (accept) begin
               ph     <= PH_SETUP;
               bit_q  <= '0;
               last_q <= nbits - 1'b1;
               rd_q   <= (kind == XK_READ);
               cs_q   <= ~(NUM_SLAVES'(1) << req_dev);
            end
            PH_SETUP: if (tick) begin
               ph     <= PH_LOW;
               sclk_q <= 1'b0;
            end
            PH_LOW: if (tick) begin
               ph     <= PH_HIGH;
               sclk_q <= 1'b1;
            end
            PH_HIGH: if (tick) begin
               if (is_last) begin
                  ph     <= PH_IDLE;
                  cs_q   <= '1;
                  done_q <= 1'b1;
                  rdat_q <= rx;
               end else begin
                  ph     <= PH_LOW;
                  sclk_q <= 1'b0;
                  bit_q  <= bit_q + 1'b1;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign busy    = (ph != PH_IDLE);
   assign done    = done_q;
   assign rd_data = rdat_q;
   assign sclk    = sclk_q;
   assign cs_n    = cs_q;
   assign cmd_out = busy && tx_bit;

   // R5
   cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1);
   // R6
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |-> sclk);
   // R6
   cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(cmd_out));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && (&cs_n)));
   // R8
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_start && !tick) |=> $stable(cs_n));
endmodule

// File: tb/sreg_bus_master_tb.sv
`timescale 1ns/1ps
module sreg_bus_master_tb;
   localparam real TCK = 4.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_div = '0;
   logic        req_start = 1'b0;
   logic [0:0]  req_dev = '0;
   logic [1:0]  req_kind = '0;
   logic        req_wide = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        busy, done, sclk, cmd_out;
   logic [15:0] rd_data;
   logic [1:0]  irq_pend, cs_n;
   logic        reply_in = 1'b0;
   logic [1:0]  irq_n = 2'b11;

   int checks = 0;
   int errors = 0;
   longint cyc = 0;

   always #(TCK/2) clk = ~clk;

   sreg_bus_master #(.ADDR_W(8), .BYTE_W(8), .NUM_SLAVES(2), .DIV_W(4), .DIV_RESET(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
      .req_start(req_start), .req_dev(req_dev), .req_kind(req_kind),
      .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .irq_pend(irq_pend),
      .sclk(sclk), .cmd_out(cmd_out), .reply_in(reply_in), .cs_n(cs_n), .irq_n(irq_n)
   );

   // slave model
   logic [23:0] patt = '0;
   logic [31:0] cap = '0;
   int rises = 0, falls = 0, cs0_low = 0, cs1_low = 0, dones = 0;
   realtime t_cs_fall, t_first_fall, t_last_rise, t_cs_rise;

   always @(negedge sclk) if (!(&cs_n)) begin
      if (falls == 0) t_first_fall = $realtime;
      reply_in <= (falls < 24) ? patt[23 - falls] : 1'b0;
      falls++;
   end
   always @(posedge sclk) if (!(&cs_n)) begin
      cap <= {cap[30:0], cmd_out};
      rises++;
      t_last_rise = $realtime;
   end
   always @(negedge cs_n[0]) begin cs0_low++; t_cs_fall = $realtime; end
   always @(negedge cs_n[1]) begin cs1_low++; t_cs_fall = $realtime; end
   always @(posedge cs_n[0]) t_cs_rise = $realtime;
   always @(posedge cs_n[1]) t_cs_rise = $realtime;
   always @(posedge clk) begin
      cyc++;
      if (done) dones++;
      if (cyc > 190000) begin
         errors++;
         $display("FAIL watchdog: actual cycles %0d expected < 190000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic reset_model();
      cap = '0; rises = 0; falls = 0; cs0_low = 0; cs1_low = 0; dones = 0;
   endtask

   task automatic pulse_start(input int dev, input int kind, input bit wide,
                              input logic [7:0] a, input logic [15:0] wd);
      @(negedge clk);
      req_dev = dev[0]; req_kind = kind[1:0]; req_wide = wide;
      req_addr = a; req_wdata = wd; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 5000) begin @(negedge clk); n++; end
      if (!done) begin
         errors++;
         $display("FAIL R9 watchdog: actual no done expected done");
      end
   endtask

   // run one transaction and check it against arithmetic expectations
   task automatic run_xfer(input int dev, input int kind, input bit wide, input int div,
                           input logic [7:0] a, input logic [15:0] wd, input logic [23:0] p);
      int nb;
      logic [31:0] exp_cap;
      logic [15:0] exp_rd;
      real h;
      h = (div + 1) * TCK;
      patt = p;
      reset_model();
      nb = (kind == 1 || kind == 2) ? (wide ? 24 : 16) : 8;
      exp_cap = {24'h0, a};
      if (kind == 1) exp_cap = wide ? {8'h0, a, wd} : {16'h0, a, wd[7:0]};
      if (kind == 2) exp_cap = wide ? {8'h0, a, 16'h0} : {16'h0, a, 8'h0};
      exp_rd = (kind == 2) ? (wide ? p[15:0] : {8'h0, p[15:8]}) : 16'h0;
      pulse_start(dev, kind, wide, a, wd);
      check("R5 selected cs low", dev == 0 ? longint'(cs_n == 2'b10) : longint'(cs_n == 2'b01), 1);
      wait_done();
      check("R9 busy low with done", busy, 0);
      check("R3 rd_data", rd_data, exp_rd);
      @(negedge clk);
      check("R9 done single cycle", done, 0);
      check("R4 clock count", rises, nb);
      check("R1 R2 command bits", cap & ((64'd1 << nb) - 1), exp_cap);
      check("R5 other cs untouched", dev == 0 ? cs1_low : cs0_low, 0);
      check("R7 lead time", longint'((t_first_fall - t_cs_fall) * 1000), longint'(h * 1000));
      check("R7 trail time", longint'((t_cs_rise - t_last_rise) * 1000), longint'(h * 1000));
      check("R7 total time", longint'((t_cs_rise - t_cs_fall) * 1000), longint'(h * (1 + 2 * nb) * 1000));
      check("R6 idle state", {sclk, cmd_out, cs_n}, 4'b1011);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R5 reset cs_n", cs_n, 2'b11);
      check("R6 reset sclk", sclk, 1);
      check("R9 reset busy done", {busy, done}, 0);
      check("R3 reset rd_data", rd_data, 0);
      check("R11 reset irq_pend", irq_pend, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: first transfer uses the reset divider 2
      run_xfer(0, 1, 1, 2, 8'hA5, 16'h3C96, 24'h0);
      // R4: general reset command, width flag has no effect
      run_xfer(1, 0, 1, 2, 8'h01, 16'hFFFF, 24'hFFFFFF);
      run_xfer(0, 3, 0, 2, 8'h80, 16'hFFFF, 24'h0);

      for (int d = 0; d < 4; d++) begin
         @(negedge clk); cfg_we = 1'b1; cfg_div = d[3:0];
         @(negedge clk); cfg_we = 1'b0;
         for (int dev = 0; dev < 2; dev++)
            for (int k = 0; k < 3; k++)
               for (int w = 0; w < 2; w++)
                  run_xfer(dev, k, w[0], d,
                           8'(37 * (d + 1) + 11 * dev + 5 * k + w),
                           16'(16'h1357 * (d + 2) + 16'h0F1 * k + w),
                           24'(24'h5A3C7 * (d + 3) + 24'h1111 * dev + k));
      end

      // R8 and R10: second start and divider write during a live transfer
      patt = 24'h00C35A;
      reset_model();
      pulse_start(0, 2, 1, 8'h42, 16'h0);
      repeat (10) @(negedge clk);
      cfg_we = 1'b1; cfg_div = 4'd0;
      req_dev = 1'b1; req_kind = 2'd1; req_addr = 8'hFF; req_wdata = 16'hFFFF; req_start = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; req_start = 1'b0;
      wait_done();
      check("R8 read data intact", rd_data, 16'hC35A);
      repeat (60) @(negedge clk);
      check("R8 no second cs", cs1_low, 0);
      check("R8 single done", dones, 1);
      check("R8 command bits intact", cap[23:0], 24'h420000);
      check("R10 timing kept old divider",
            longint'((t_cs_rise - t_cs_fall) * 1000), longint'(4 * TCK * 49 * 1000));
      run_xfer(1, 1, 0, 0, 8'h7E, 16'h00B1, 24'h0);

      // R11 interrupt pass-through
      for (int v = 0; v < 4; v++) begin
         @(negedge clk); irq_n = v[1:0];
         @(negedge clk);
         @(negedge clk);
         check("R11 irq_pend", irq_pend, ~v[1:0] & 2'b11);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule